// File: doc/BRIEF.md
# USB Bus Reset Detector

This block watches the two data lines of an upstream USB port and decides when the host has signalled a bus reset. A bus reset is a single-ended zero (both lines low) held for long enough. The lines pass through a synchronizer. A duration timer then counts consecutive single-ended-zero samples in system clocks. When the count reaches a threshold that is set by a parameter, the reset is recognized.

On recognition the block sets a sticky status bit, which stays set until software pulses a clear strobe. If the power-on start-up delay is still running at that moment, the block also emits a one-cycle abort strobe that ends the delay early. The bus-reset interrupt is a one-cycle pulse raised when the single-ended zero ends, not when it is first recognized. The default threshold is 168 clocks, which is 14 µs at 12 MHz. This sits inside the band between the shortest duration that may count as a reset and the longest duration that must be ignored.

Top module: `usb_busreset_det`

## Requirements
- R1: A sample counts as single-ended zero only when both D+ and D- are low. A sample with one line low and the other high never advances recognition.
- R2: A single-ended zero lasting fewer than THRESH_CYC samples (default 168) never sets the status bit.
- R3: A single-ended zero lasting THRESH_CYC samples or more sets the status bit.
- R4: Once set, the status bit stays high until the clear strobe is sampled high. A clear sampled with no new recognition drops it on the next edge.
- R5: A clear strobe sampled on the same edge as a new recognition leaves the status bit set.
- R6: After a recognized reset, the interrupt output pulses high for exactly one cycle after the lines leave single-ended zero. A single-ended zero that is too short raises no interrupt.
- R7: The abort strobe pulses high for exactly one cycle at recognition, but only if the start-up-active input is high then. Otherwise it stays low.
- R8: Any non-single-ended-zero sample restarts the duration count from zero.
- R9: The duration count saturates. However long the single-ended zero lasts, it yields exactly one recognition and one interrupt.
- R10: While reset is asserted, all three outputs are low.
- R11: The status bit rises on the (THRESH_CYC+2)-th rising clock edge after both lines go low. Two of these edges are synchronizer latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_i | input | 1 | D+ line, asynchronous |
| dm_i | input | 1 | D- line, asynchronous |
| stat_clr_i | input | 1 | Clear strobe for the status bit |
| startup_busy_i | input | 1 | High while the power-on start-up delay runs |
| rst_stat_o | output | 1 | Sticky bus-reset status bit |
| rst_irq_o | output | 1 | One-cycle bus-reset interrupt at end of single-ended zero |
| startup_abort_o | output | 1 | One-cycle strobe to end the start-up delay |

## Verification
The assertions check the following on every cycle:
- the interrupt and abort strobes last only one cycle;
- an abort is only issued when start-up was active, and it always comes with the status bit set;
- the status bit holds unless cleared, and a clear with no single-ended zero drops it;
- the status bit only rises when the count sits at the threshold, and the count never passes the threshold.

Only the bench scenarios can show the following:
- the exact boundary between THRESH_CYC-1 and THRESH_CYC samples, and the two-edge synchronizer latency;
- that a single high glitch restarts the count;
- that a half-low line pair is ignored;
- that a very long single-ended zero yields exactly one recognition.

// File: rtl/usb_brd_pkg.sv
package usb_brd_pkg;

   // Width needed to hold a count from 0 up to and including lim.
   function automatic int cnt_width(input int lim);
      return (lim < 1) ? 1 : $clog2(lim + 1);
   endfunction

   typedef struct packed {
      logic dp;
      logic dm;
   } usb_line_t;

endpackage

// File: rtl/usb_brd_sync.sv
module usb_brd_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] chain_q [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("usb_brd_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[s] <= RST_VAL;
            end else if (s == 0) begin
               chain_q[s] <= d_i;
            end else begin
               chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/usb_brd_se0_timer.sv
module usb_brd_se0_timer #(
   parameter int THRESH_CYC = 168,
   parameter int CNT_W      = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  usb_brd_pkg::usb_line_t  line_i,
   output logic                    se0_o,
   output logic [CNT_W-1:0]        cnt_o,
   output logic                    hit_o,
   output logic                    long_o
);

   localparam logic [CNT_W-1:0] LIM      = CNT_W'(THRESH_CYC);
   localparam logic [CNT_W-1:0] LIM_LESS = CNT_W'(THRESH_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   assign se0_o = ~line_i.dp & ~line_i.dm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!se0_o) begin
         cnt_q <= '0;
      end else if (cnt_q != LIM) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // hit_o marks the single cycle in which the count steps onto the limit.
   assign hit_o  = se0_o && (cnt_q == LIM_LESS);
   assign long_o = (cnt_q == LIM);
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/usb_brd_event.sv
module usb_brd_event (
   input  logic clk,
   input  logic rst_n,
   input  logic hit_i,
   input  logic long_i,
   input  logic se0_i,
   input  logic clr_i,
   input  logic busy_i,
   output logic stat_o,
   output logic irq_o,
   output logic abort_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_o  <= 1'b0;
         irq_o   <= 1'b0;
         abort_o <= 1'b0;
      end else begin
         // Recognition outranks the clear strobe.
         if (hit_i) begin
            stat_o <= 1'b1;
         end else if (clr_i) begin
            stat_o <= 1'b0;
         end
         irq_o   <= long_i && !se0_i;
         abort_o <= hit_i && busy_i;
      end
   end

endmodule

// File: rtl/usb_busreset_det.sv
module usb_busreset_det #(
   parameter int THRESH_CYC  = 168,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dp_i,
   input  logic dm_i,
   input  logic stat_clr_i,
   input  logic startup_busy_i,
   output logic rst_stat_o,
   output logic rst_irq_o,
   output logic startup_abort_o
);

   localparam int CNT_W = usb_brd_pkg::cnt_width(THRESH_CYC);

   generate
      if (THRESH_CYC < 2) begin : g_bad_thresh
         $error("usb_busreset_det: THRESH_CYC must be at least 2");
      end
   endgenerate

   logic [1:0]             raw_w;
   logic [1:0]             sync_w;
   usb_brd_pkg::usb_line_t line_w;
   logic                   se0_w;
   logic [CNT_W-1:0]       cnt_w;
   logic                   hit_w;
   logic                   long_w;

   assign raw_w       = {dp_i, dm_i};
   assign line_w.dp   = sync_w[1];
   assign line_w.dm   = sync_w[0];

   usb_brd_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (2),
      .RST_VAL (2'b11)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_w),
      .q_o   (sync_w)
   );

   usb_brd_se0_timer #(
      .THRESH_CYC (THRESH_CYC),
      .CNT_W      (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_w),
      .se0_o  (se0_w),
      .cnt_o  (cnt_w),
      .hit_o  (hit_w),
      .long_o (long_w)
   );

   usb_brd_event u_event (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit_i   (hit_w),
      .long_i  (long_w),
      .se0_i   (se0_w),
      .clr_i   (stat_clr_i),
      .busy_i  (startup_busy_i),
      .stat_o  (rst_stat_o),
      .irq_o   (rst_irq_o),
      .abort_o (startup_abort_o)
   );

endmodule

// File: rtl/usb_busreset_det_chk.sv
module usb_busreset_det_chk #(
   parameter int THRESH_CYC = 168,
   parameter int CNT_W      = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             stat_clr_i,
   input logic             startup_busy_i,
   input logic             rst_stat_o,
   input logic             rst_irq_o,
   input logic             startup_abort_o,
   input logic             se0_i,
   input logic [CNT_W-1:0] cnt_i
);

   localparam logic [CNT_W-1:0] LIM = CNT_W'(THRESH_CYC);

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_irq_o |=> !rst_irq_o); // R6
   AST_IRQ_AFTER_RECOG: assert property (@(posedge clk) disable iff (!rst_n)
      rst_irq_o |-> $past(cnt_i == LIM)); // R6
   AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      startup_abort_o |=> !startup_abort_o); // R7
   AST_ABORT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      startup_abort_o |-> $past(startup_busy_i)); // R7
   AST_ABORT_WITH_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      startup_abort_o |-> rst_stat_o); // R7
   AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_stat_o && !stat_clr_i) |=> rst_stat_o); // R4
   AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_clr_i && !se0_i) |=> !rst_stat_o); // R4
   AST_STAT_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_stat_o) |-> (cnt_i == LIM)); // R3
   AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_i <= LIM); // R9

endmodule

bind usb_busreset_det usb_busreset_det_chk #(
   .THRESH_CYC (THRESH_CYC),
   .CNT_W      (CNT_W)
) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .stat_clr_i      (stat_clr_i),
   .startup_busy_i  (startup_busy_i),
   .rst_stat_o      (rst_stat_o),
   .rst_irq_o       (rst_irq_o),
   .startup_abort_o (startup_abort_o),
   .se0_i           (se0_w),
   .cnt_i           (cnt_w)
);

// File: tb/usb_busreset_det_tb.sv
module usb_busreset_det_tb;

   localparam int TH = 168;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dp = 1'b1;
   logic dm = 1'b1;
   logic clr = 1'b0;
   logic busy = 1'b0;
   logic stat, irq, abrt;

   int n_chk = 0;
   int n_bad = 0;
   int irq_cnt = 0;
   int abort_cnt = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   usb_busreset_det #(.THRESH_CYC(TH)) u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .dp_i            (dp),
      .dm_i            (dm),
      .stat_clr_i      (clr),
      .startup_busy_i  (busy),
      .rst_stat_o      (stat),
      .rst_irq_o       (irq),
      .startup_abort_o (abrt)
   );

   always @(negedge clk) begin
      if (irq)  irq_cnt   <= irq_cnt + 1;
      if (abrt) abort_cnt <= abort_cnt + 1;
   end

   typedef struct packed {
      int len;
      bit busy;
      bit e_stat;
      int e_irq;
      int e_abort;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{len: 5,      busy: 1'b0, e_stat: 1'b0, e_irq: 0, e_abort: 0},
      '{len: TH-1,   busy: 1'b0, e_stat: 1'b0, e_irq: 0, e_abort: 0},
      '{len: TH,     busy: 1'b0, e_stat: 1'b1, e_irq: 1, e_abort: 0},
      '{len: TH+1,   busy: 1'b0, e_stat: 1'b1, e_irq: 1, e_abort: 0},
      '{len: 200,    busy: 1'b0, e_stat: 1'b1, e_irq: 1, e_abort: 0},
      '{len: 700,    busy: 1'b0, e_stat: 1'b1, e_irq: 1, e_abort: 0},
      '{len: TH,     busy: 1'b1, e_stat: 1'b1, e_irq: 1, e_abort: 1},
      '{len: 300,    busy: 1'b1, e_stat: 1'b1, e_irq: 1, e_abort: 1},
      '{len: TH-1,   busy: 1'b1, e_stat: 1'b0, e_irq: 0, e_abort: 0},
      '{len: 1,      busy: 1'b1, e_stat: 1'b0, e_irq: 0, e_abort: 0}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      @(negedge clk);
   endtask

   task automatic hold_lines(input logic p, input logic m, input int n);
      dp = p; dm = m;
      repeat (n) @(negedge clk);
      dp = 1'b1; dm = 1'b1;
   endtask

   task automatic settle_and_zero();
      repeat (8) @(negedge clk);
      irq_cnt = 0; abort_cnt = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      report();
   end

   initial begin
      // R10: outputs low under reset
      repeat (3) @(negedge clk);
      check(!stat && !irq && !abrt, "R10 reset outputs", {stat, irq, abrt}, 0);
      rst_n = 1'b1;
      settle_and_zero();

      // Vector table: R2 R3 R6 R7 R9
      for (int i = 0; i < NV; i++) begin
         pulse_clr();
         busy = VECS[i].busy;
         irq_cnt = 0; abort_cnt = 0;
         @(negedge clk);
         hold_lines(1'b0, 1'b0, VECS[i].len);
         repeat (8) @(negedge clk);
         busy = 1'b0;
         check(stat == VECS[i].e_stat, VECS[i].e_stat ? "R3 status set" : "R2 status clear",
               stat, VECS[i].e_stat);
         check(irq_cnt == VECS[i].e_irq, "R6 irq pulses", irq_cnt, VECS[i].e_irq);
         check(abort_cnt == VECS[i].e_abort, "R7 abort pulses", abort_cnt, VECS[i].e_abort);
         repeat (20) @(negedge clk);
         check(stat == VECS[i].e_stat, "R4 status held", stat, VECS[i].e_stat);
      end

      // R1: only one line low does not count
      pulse_clr(); irq_cnt = 0;
      hold_lines(1'b0, 1'b1, 400);
      hold_lines(1'b1, 1'b0, 400);
      settle_and_zero();
      check(stat == 1'b0, "R1 half-low ignored", stat, 0);
      hold_lines(1'b0, 1'b0, TH - 100);
      hold_lines(1'b0, 1'b1, 1);
      hold_lines(1'b0, 1'b0, 100);
      settle_and_zero();
      check(stat == 1'b0, "R1 half-low sample breaks count", stat, 0);

      // R8: one idle sample restarts the count
      pulse_clr(); irq_cnt = 0;
      hold_lines(1'b0, 1'b0, 120);
      hold_lines(1'b1, 1'b1, 1);
      hold_lines(1'b0, 1'b0, 120);
      repeat (8) @(negedge clk);
      check(stat == 1'b0, "R8 glitch restarts count", stat, 0);
      check(irq_cnt == 0, "R8 no irq after split SE0", irq_cnt, 0);

      // R9: clear mid-way through a long SE0, no second recognition
      pulse_clr(); irq_cnt = 0; abort_cnt = 0;
      busy = 1'b1;
      dp = 1'b0; dm = 1'b0;
      repeat (TH + 20) @(negedge clk);
      clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      repeat (600) @(negedge clk);
      check(stat == 1'b0, "R9 no re-recognition", stat, 0);
      dp = 1'b1; dm = 1'b1;
      repeat (8) @(negedge clk);
      busy = 1'b0;
      check(irq_cnt == 1, "R9 single irq", irq_cnt, 1);
      check(abort_cnt == 1, "R9 single abort", abort_cnt, 1);

      // R11 latency and R5 clear collision
      pulse_clr();
      dp = 1'b0; dm = 1'b0;
      repeat (TH + 1) @(negedge clk);
      check(stat == 1'b0, "R11 not yet set", stat, 0);
      clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      check(stat == 1'b1, "R5 set wins over clear", stat, 1);
      check(stat == 1'b1, "R11 set on edge TH+2", stat, 1);
      dp = 1'b1; dm = 1'b1;
      settle_and_zero();

      // R4: clear drops the bit on the next edge
      check(stat == 1'b1, "R4 still set", stat, 1);
      @(negedge clk) clr = 1'b1;
      @(negedge clk) clr = 1'b0;
      check(stat == 1'b0, "R4 clear next edge", stat, 0);
      repeat (10) @(negedge clk);
      check(stat == 1'b0, "R4 stays clear", stat, 0);

      // R10: reset mid-recognition clears outputs
      dp = 1'b0; dm = 1'b0;
      repeat (TH + 10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(!stat && !irq && !abrt, "R10 reset clears", {stat, irq, abrt}, 0);
      dp = 1'b1; dm = 1'b1;
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      report();
   end

endmodule